// File: doc/BRIEF.md
# Serial FIFO Error and Request Controller

This block connects a processor or DMA bus to a synchronous serial shifter. It has two 16-word FIFOs. The transmit FIFO is filled by bus writes and drained by the shifter. The receive FIFO is filled by the shifter and drained by bus reads. From the FIFO fill levels the block derives a transmit data request and a receive data request, each compared against a programmable threshold. It drives one registered request flag per direction toward an interrupt or DMA controller. A DMA acknowledge drops the matching flag for one cycle.

The block watches for five faults:
- the shifter popping an empty transmit FIFO;
- the bus writing a full transmit FIFO;
- the shifter pushing into a full receive FIFO;
- the bus reading an empty receive FIFO;
- a frame-sync error strobe.

Each fault has a fixed recovery and a sticky status bit. The status bits are cleared by writing 1 to them. A mask register selects which status bits drive the single interrupt output. A frame slot counter advances on shifter bit ticks and is forced back to zero by the frame-sync error strobe.

Register map (3-bit `bus_addr`): 0 = data (write pushes TX, read pops RX), 1 = status, 2 = interrupt mask, 3 = thresholds, 4 = levels (read only). Reads return data on `bus_rdata` one clock after `bus_rd`.

Top module: `serfifo_err_ctrl`

## Requirements
- R1: In reset, `irq`, `tx_dreq`, `rx_dreq`, `sh_tx_data` and `bus_rdata` are 0. Both FIFOs are empty and the mask is 0. The thresholds read back 0x0108 (TX 8 in bits [4:0], RX 1 in bits [12:8]).
- R2: Words written to address 0 leave on `sh_tx_data` in write order, one clock after each `sh_tx_pop`. Words pushed by the shifter come back in order on address-0 reads. Address 4 shows the TX count in bits [4:0] and the RX count in bits [12:8].
- R3: Status bit 0 (TX request) is 1 while the TX count is at or below the TX threshold. Status bit 1 (RX request) is 1 while the RX count is at or above the RX threshold. Address 3 holds the thresholds in the same field positions as address 4.
- R4: `tx_dreq` is 1 in the clock after status bit 0 was 1 with `tx_ack` low. It is 0 in the clock after `tx_ack` was high or status bit 0 was 0. `rx_dreq` follows the same rule with status bit 1 and `rx_ack`.
- R5: A pop of an empty TX FIFO leaves `sh_tx_data` holding the previous word and sets status bit 2.
- R6: A write to a TX FIFO that is full at the start of the cycle is dropped, even if a pop happens in the same cycle. The stored words are unchanged and status bit 3 is set.
- R7: A shifter push into an RX FIFO that is full at the start of the cycle is discarded, even if a bus read happens in the same cycle. Status bit 4 is set.
- R8: A read of address 0 with the RX FIFO empty returns the last word popped from it (0 if none) and sets status bit 5.
- R9: The slot counter in status bits [11:8] counts `sh_tick` pulses modulo 16. `sh_fserr` forces it to 0 (overriding a tick in the same cycle) and sets status bit 6.
- R10: Writing address 1 clears each of status bits 2..6 whose data bit is 1. Bits 0 and 1 are not affected. A fault in the same cycle as a clear leaves its bit set.
- R11: `irq` is 1 exactly when some status bit 0..6 and its mask bit (address 2, bits [6:0]) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| sh_tx_pop | input | 1 | Shifter takes the next transmit word |
| sh_tx_data | output | 16 | Word presented to the shifter |
| sh_rx_push | input | 1 | Shifter delivers a received word |
| sh_rx_data | input | 16 | Received word |
| sh_tick | input | 1 | Advance the frame slot counter |
| sh_fserr | input | 1 | Frame-sync error strobe |
| tx_ack | input | 1 | DMA acknowledge, transmit side |
| rx_ack | input | 1 | DMA acknowledge, receive side |
| tx_dreq | output | 1 | Transmit request flag |
| rx_dreq | output | 1 | Receive request flag |
| irq | output | 1 | Combined masked interrupt |

## Verification
Two pairs of functions can land in one cycle, and the bench provokes both directly.

The first pair is an overflow and a drain of the same FIFO. A bus write is issued into a full TX FIFO together with a shifter pop, and a shifter push is issued into a full RX FIFO together with a bus read. In both cases the scoreboard expects the popped word and then the fifteen remaining words in order, with no trace of the dropped word. The level register must read 15.

The second pair is a status clear and a new fault of the same kind. A write-1-clear of all error bits is issued while the shifter pops an empty TX FIFO. The bench expects the underrun bit to stay set while the other error bits clear.

// File: rtl/serfifo_pkg.sv
package serfifo_pkg;
  typedef enum logic [2:0] {
    RA_DATA = 3'd0,
    RA_STAT = 3'd1,
    RA_MASK = 3'd2,
    RA_THR  = 3'd3,
    RA_LVL  = 3'd4
  } reg_addr_e;

  // status vector layout: two level bits, then the sticky fault bits
  localparam int NSRC = 7;
  localparam int NERR = 5;
  localparam int SB_TXREQ = 0;
  localparam int SB_RXREQ = 1;
  localparam int SB_TXUND = 2;
  localparam int SB_TXOVF = 3;
  localparam int SB_RXOVF = 4;
  localparam int SB_RXUND = 5;
  localparam int SB_FSYNC = 6;
  localparam int FIELD_HI = 8;  // bit offset of the upper count field
endpackage

// File: rtl/serfifo_fifo.sv
module serfifo_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = mem[rptr_q];
  assign count   = cnt_q;

  always_comb begin
    wptr_d = do_push ? bump(wptr_q) : wptr_q;
    rptr_d = do_pop  ? bump(rptr_q) : rptr_q;
    cnt_d  = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= din;
  end
endmodule

// File: rtl/serfifo_reqflag.sv
module serfifo_reqflag (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic ack,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb flag_d = level & ~ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/serfifo_slotctr.sv
module serfifo_slotctr #(
  parameter int FRAME_BITS = 16,
  localparam int SW = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          resync,
  output logic [SW-1:0] slot
);
  logic [SW-1:0] slot_q, slot_d;

  always_comb begin
    if (resync)                                slot_d = '0;
    else if (tick && slot_q == SW'(FRAME_BITS - 1)) slot_d = '0;
    else if (tick)                             slot_d = slot_q + SW'(1);
    else                                       slot_d = slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assign slot = slot_q;
endmodule

// File: rtl/serfifo_err_ctrl.sv
module serfifo_err_ctrl
  import serfifo_pkg::*;
#(
  parameter int DW         = 16,
  parameter int DEPTH      = 16,
  parameter int FRAME_BITS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          sh_tx_pop,
  output logic [DW-1:0] sh_tx_data,
  input  logic          sh_rx_push,
  input  logic [DW-1:0] sh_rx_data,
  input  logic          sh_tick,
  input  logic          sh_fserr,
  input  logic          tx_ack,
  input  logic          rx_ack,
  output logic          tx_dreq,
  output logic          rx_dreq,
  output logic          irq
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = $clog2(FRAME_BITS);
  localparam int PADW = FIELD_HI - CW;

  logic          hit_data_wr, hit_data_rd, hit_stat_wr, hit_mask_wr, hit_thr_wr;
  logic [DW-1:0] tx_head, rx_head;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          lvl_tx, lvl_rx;
  logic [SW-1:0] slot_cnt;
  logic [NERR-1:0] err_q, err_d, err_set, err_clr;
  logic [NSRC-1:0] mask_q, mask_d, sts_all;
  logic [CW-1:0] thr_tx_q, thr_tx_d, thr_rx_q, thr_rx_d;
  logic [DW-1:0] rdata_q, rdata_d, last_rd_q, last_rd_d, txo_q, txo_d, rd_val;

  // ---- address decode
  assign hit_data_wr = bus_wr && (bus_addr == RA_DATA);
  assign hit_data_rd = bus_rd && (bus_addr == RA_DATA);
  assign hit_stat_wr = bus_wr && (bus_addr == RA_STAT);
  assign hit_mask_wr = bus_wr && (bus_addr == RA_MASK);
  assign hit_thr_wr  = bus_wr && (bus_addr == RA_THR);

  // ---- storage
  serfifo_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(hit_data_wr), .din(bus_wdata),
    .pop(sh_tx_pop), .head(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  serfifo_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(sh_rx_push), .din(sh_rx_data),
    .pop(hit_data_rd), .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  // ---- level requests and their flags
  assign lvl_tx = (tx_cnt <= thr_tx_q);
  assign lvl_rx = (rx_cnt >= thr_rx_q);

  serfifo_reqflag u_txflag (
    .clk(clk), .rst_n(rst_n), .level(lvl_tx), .ack(tx_ack), .flag(tx_dreq)
  );
  serfifo_reqflag u_rxflag (
    .clk(clk), .rst_n(rst_n), .level(lvl_rx), .ack(rx_ack), .flag(rx_dreq)
  );

  // ---- frame slot counter
  serfifo_slotctr #(.FRAME_BITS(FRAME_BITS)) u_slot (
    .clk(clk), .rst_n(rst_n), .tick(sh_tick), .resync(sh_fserr), .slot(slot_cnt)
  );

  // ---- fault detection: judged on occupancy at the start of the cycle
  always_comb begin
    err_set[SB_TXUND - 2] = sh_tx_pop   & tx_empty;
    err_set[SB_TXOVF - 2] = hit_data_wr & tx_full;
    err_set[SB_RXOVF - 2] = sh_rx_push  & rx_full;
    err_set[SB_RXUND - 2] = hit_data_rd & rx_empty;
    err_set[SB_FSYNC - 2] = sh_fserr;
    err_clr = hit_stat_wr ? bus_wdata[SB_FSYNC:SB_TXUND] : '0;
  end

  assign sts_all = {err_q, lvl_rx, lvl_tx};
  assign irq     = |(sts_all & mask_q);

  // ---- read mux
  always_comb begin
    case (bus_addr)
      RA_DATA: rd_val = rx_empty ? last_rd_q : rx_head;
      RA_STAT: rd_val = DW'({slot_cnt, 1'b0, sts_all});
      RA_MASK: rd_val = DW'(mask_q);
      RA_THR:  rd_val = DW'({thr_rx_q, {PADW{1'b0}}, thr_tx_q});
      RA_LVL:  rd_val = DW'({rx_cnt, {PADW{1'b0}}, tx_cnt});
      default: rd_val = '0;
    endcase
  end

  // ---- next state
  always_comb begin
    err_d     = (err_q & ~err_clr) | err_set;
    mask_d    = hit_mask_wr ? bus_wdata[NSRC-1:0] : mask_q;
    thr_tx_d  = hit_thr_wr ? bus_wdata[CW-1:0] : thr_tx_q;
    thr_rx_d  = hit_thr_wr ? bus_wdata[FIELD_HI +: CW] : thr_rx_q;
    rdata_d   = bus_rd ? rd_val : rdata_q;
    last_rd_d = (hit_data_rd && !rx_empty) ? rx_head : last_rd_q;
    txo_d     = (sh_tx_pop && !tx_empty) ? tx_head : txo_q;
  end

  // ---- registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q     <= '0;
      mask_q    <= '0;
      thr_tx_q  <= CW'(DEPTH / 2);
      thr_rx_q  <= CW'(1);
      rdata_q   <= '0;
      last_rd_q <= '0;
      txo_q     <= '0;
    end else begin
      err_q     <= err_d;
      mask_q    <= mask_d;
      thr_tx_q  <= thr_tx_d;
      thr_rx_q  <= thr_rx_d;
      rdata_q   <= rdata_d;
      last_rd_q <= last_rd_d;
      txo_q     <= txo_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign sh_tx_data = txo_q;
endmodule

// File: rtl/serfifo_err_ctrl_chk.sv
module serfifo_err_ctrl_chk
  import serfifo_pkg::*;
#(
  parameter int DW         = 16,
  parameter int DEPTH      = 16,
  parameter int FRAME_BITS = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int SW = $clog2(FRAME_BITS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      bus_addr,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [DW-1:0]   bus_rdata,
  input logic            sh_tx_pop,
  input logic [DW-1:0]   sh_tx_data,
  input logic            sh_rx_push,
  input logic            sh_fserr,
  input logic            tx_ack,
  input logic            rx_ack,
  input logic            tx_dreq,
  input logic            rx_dreq,
  input logic            irq,
  input logic            tx_full,
  input logic            tx_empty,
  input logic            rx_full,
  input logic            rx_empty,
  input logic [CW-1:0]   tx_cnt,
  input logic [CW-1:0]   rx_cnt,
  input logic [DW-1:0]   last_rd_q,
  input logic [SW-1:0]   slot_cnt,
  input logic [NSRC-1:0] sts_all,
  input logic [NSRC-1:0] mask_q
);
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

  a_r4_tx_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack |=> !tx_dreq);

  a_r4_rx_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack |=> !rx_dreq);

  a_r5_tx_resend: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_tx_pop && tx_empty) |=> ($stable(sh_tx_data) && sts_all[SB_TXUND]));

  a_r6_tx_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RA_DATA && tx_full) |=> sts_all[SB_TXOVF]);

  a_r6_tx_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RA_DATA && tx_full && !sh_tx_pop) |=> tx_full);

  a_r7_rx_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_rx_push && rx_full && !(bus_rd && bus_addr == RA_DATA)) |=> (rx_full && sts_all[SB_RXOVF]));

  a_r8_rx_stale: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == RA_DATA && rx_empty) |=> (bus_rdata == $past(last_rd_q) && sts_all[SB_RXUND]));

  a_r9_fs_resync: assert property (@(posedge clk) disable iff (!rst_n)
    sh_fserr |=> (slot_cnt == '0 && sts_all[SB_FSYNC]));

  a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
endmodule

bind serfifo_err_ctrl serfifo_err_ctrl_chk #(
  .DW(DW), .DEPTH(DEPTH), .FRAME_BITS(FRAME_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .sh_tx_pop(sh_tx_pop), .sh_tx_data(sh_tx_data),
  .sh_rx_push(sh_rx_push), .sh_fserr(sh_fserr), .tx_ack(tx_ack), .rx_ack(rx_ack),
  .tx_dreq(tx_dreq), .rx_dreq(rx_dreq), .irq(irq), .tx_full(tx_full),
  .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty), .tx_cnt(tx_cnt),
  .rx_cnt(rx_cnt), .last_rd_q(last_rd_q), .slot_cnt(slot_cnt), .sts_all(sts_all),
  .mask_q(mask_q)
);

// File: tb/serfifo_err_ctrl_test.sv
module serfifo_err_ctrl_test;
  logic        clk, rst_n;
  logic [2:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata, bus_rdata;
  logic        sh_tx_pop, sh_rx_push, sh_tick, sh_fserr, tx_ack, rx_ack;
  logic [15:0] sh_tx_data, sh_rx_data;
  logic        tx_dreq, rx_dreq, irq;

  int n_vec = 0;
  int n_bad = 0;

  serfifo_err_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sh_tx_pop(sh_tx_pop),
    .sh_tx_data(sh_tx_data), .sh_rx_push(sh_rx_push), .sh_rx_data(sh_rx_data),
    .sh_tick(sh_tick), .sh_fserr(sh_fserr), .tx_ack(tx_ack), .rx_ack(rx_ack),
    .tx_dreq(tx_dreq), .rx_dreq(rx_dreq), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  // reference models and scoreboard queues
  logic [15:0] txm[$];
  logic [15:0] rxm[$];
  logic [15:0] tx_exp[$];
  logic [15:0] rx_exp[$];
  string       tx_tag[$];
  string       rx_tag[$];
  logic [15:0] tx_last = 16'h0;
  logic [15:0] rx_last = 16'h0;
  logic        txp_d = 1'b0;
  logic        rxr_d = 1'b0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // monitor: captures which results are due, compares at the falling edge
  always @(posedge clk) begin
    txp_d <= sh_tx_pop & rst_n;
    rxr_d <= bus_rd & (bus_addr == 3'd0) & rst_n;
  end

  always @(negedge clk) begin
    if (txp_d) begin
      if (tx_exp.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R2 unexpected tx word actual=%h expected=none", sh_tx_data);
      end else chk(tx_tag.pop_front(), sh_tx_data, tx_exp.pop_front());
    end
    if (rxr_d) begin
      if (rx_exp.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R2 unexpected rx word actual=%h expected=none", bus_rdata);
      end else chk(rx_tag.pop_front(), bus_rdata, rx_exp.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  // ---- driver
  task automatic cyc();
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; sh_tx_pop = 0; sh_rx_push = 0;
    sh_tick = 0; sh_fserr = 0; tx_ack = 0; rx_ack = 0;
  endtask

  task automatic prep_txwr(input logic [15:0] d);
    bus_addr = 3'd0; bus_wdata = d; bus_wr = 1;
    if (txm.size() < 16) txm.push_back(d);
  endtask

  task automatic prep_txpop(input string tag);
    sh_tx_pop = 1;
    if (txm.size() > 0) tx_last = txm.pop_front();
    tx_exp.push_back(tx_last);
    tx_tag.push_back(tag);
  endtask

  task automatic prep_rxpush(input logic [15:0] d);
    sh_rx_push = 1; sh_rx_data = d;
    if (rxm.size() < 16) rxm.push_back(d);
  endtask

  task automatic prep_rxrd(input string tag);
    bus_addr = 3'd0; bus_rd = 1;
    if (rxm.size() > 0) rx_last = rxm.pop_front();
    rx_exp.push_back(rx_last);
    rx_tag.push_back(tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    cyc();
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    bus_addr = a; bus_rd = 1;
    cyc();
    v = bus_rdata;
  endtask

  logic [15:0] v;

  initial begin
    rst_n = 0; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
    sh_tx_pop = 0; sh_rx_push = 0; sh_rx_data = 0; sh_tick = 0; sh_fserr = 0;
    tx_ack = 0; rx_ack = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 irq", {15'h0, irq}, 16'h0);
    chk("R1 tx_dreq", {15'h0, tx_dreq}, 16'h0);
    chk("R1 rx_dreq", {15'h0, rx_dreq}, 16'h0);
    chk("R1 sh_tx_data", sh_tx_data, 16'h0);
    chk("R1 bus_rdata", bus_rdata, 16'h0);
    rst_n = 1;
    cyc();
    rd(3'd3, v); chk("R1 thresholds", v, 16'h0108);
    rd(3'd2, v); chk("R1 mask", v, 16'h0000);
    rd(3'd4, v); chk("R1 levels", v, 16'h0000);
    rd(3'd1, v); chk("R3 status after reset", v, 16'h0001);
    chk("R4 tx_dreq follows request", {15'h0, tx_dreq}, 16'h1);

    // R2: ordered transmit path
    for (int i = 1; i <= 3; i++) begin prep_txwr(16'h0A00 + 16'(i)); cyc(); end
    rd(3'd4, v); chk("R2 tx level", v, 16'h0003);
    for (int i = 0; i < 3; i++) begin prep_txpop("R2 tx order"); cyc(); end
    // R5: underrun resends
    prep_txpop("R5 tx resend"); cyc();
    rd(3'd1, v); chk("R5 underrun bit", v & 16'h007F, 16'h0005);

    // R11 / R10: mask and clear
    wr(3'd2, 16'h0004);
    chk("R11 irq on masked fault", {15'h0, irq}, 16'h1);
    wr(3'd1, 16'h0004);
    chk("R10 irq after clear", {15'h0, irq}, 16'h0);
    rd(3'd1, v); chk("R10 status after clear", v, 16'h0001);
    wr(3'd2, 16'h0000);

    // R4: acknowledge drops the flag for a cycle
    tx_ack = 1; cyc();
    chk("R4 tx ack clears", {15'h0, tx_dreq}, 16'h0);
    cyc();
    chk("R4 tx flag returns", {15'h0, tx_dreq}, 16'h1);

    // R6: overrun with a same-cycle pop
    for (int i = 0; i < 16; i++) begin prep_txwr(16'h0100 + 16'(i)); cyc(); end
    rd(3'd4, v); chk("R2 tx full level", v, 16'h0010);
    chk("R3 tx flag off when full", {15'h0, tx_dreq}, 16'h0);
    prep_txwr(16'hDEAD); prep_txpop("R6 pop beside dropped write"); cyc();
    rd(3'd4, v); chk("R6 level after drop", v, 16'h000F);
    rd(3'd1, v); chk("R6 overrun bit", v & 16'h000B, 16'h0008);
    for (int i = 0; i < 15; i++) begin prep_txpop("R6 contents kept"); cyc(); end
    prep_txpop("R5 resend after drain"); cyc();
    rd(3'd1, v); chk("R5 R6 status", v & 16'h007F, 16'h000D);
    wr(3'd1, 16'h007C);
    rd(3'd1, v); chk("R10 clear all", v, 16'h0001);

    // R3 / R4 receive side
    wr(3'd3, 16'h0208);
    prep_rxpush(16'h0200); cyc();
    rd(3'd1, v); chk("R3 rx below threshold", v & 16'h0002, 16'h0000);
    prep_rxpush(16'h0201); cyc();
    rd(3'd1, v); chk("R3 rx at threshold", v & 16'h0002, 16'h0002);
    chk("R4 rx flag set", {15'h0, rx_dreq}, 16'h1);
    rx_ack = 1; cyc();
    chk("R4 rx ack clears", {15'h0, rx_dreq}, 16'h0);
    cyc();
    chk("R4 rx flag returns", {15'h0, rx_dreq}, 16'h1);
    prep_rxrd("R2 rx order"); cyc();
    prep_rxrd("R2 rx order"); cyc();
    // R8: stale read
    prep_rxrd("R8 stale word"); cyc();
    rd(3'd1, v); chk("R8 underrun bit", v & 16'h0020, 16'h0020);

    // R7: overrun with a same-cycle read
    for (int i = 0; i < 16; i++) begin prep_rxpush(16'h0300 + 16'(i)); cyc(); end
    rd(3'd4, v); chk("R2 rx full level", v, 16'h1000);
    prep_rxpush(16'hBEEF); prep_rxrd("R7 read beside dropped push"); cyc();
    rd(3'd4, v); chk("R7 level after drop", v, 16'h0F00);
    rd(3'd1, v); chk("R7 overrun bit", v & 16'h0010, 16'h0010);
    for (int i = 0; i < 15; i++) begin prep_rxrd("R7 no dropped word"); cyc(); end
    rd(3'd4, v); chk("R7 drained", v, 16'h0000);

    // R9: slot counter and sync error
    wr(3'd1, 16'h007C);
    for (int i = 0; i < 5; i++) begin sh_tick = 1; cyc(); end
    rd(3'd1, v); chk("R9 slot count", (v >> 8) & 16'h000F, 16'h0005);
    sh_fserr = 1; sh_tick = 1; cyc();
    rd(3'd1, v); chk("R9 resync and flag", v & 16'h0F40, 16'h0040);
    for (int i = 0; i < 17; i++) begin sh_tick = 1; cyc(); end
    rd(3'd1, v); chk("R9 wrap", (v >> 8) & 16'h000F, 16'h0001);

    // R10: clear colliding with a new underrun
    bus_addr = 3'd1; bus_wdata = 16'h007C; bus_wr = 1; prep_txpop("R10 resend during clear"); cyc();
    rd(3'd1, v); chk("R10 set wins over clear", v & 16'h007C, 16'h0004);
    wr(3'd1, 16'h0003);
    rd(3'd1, v); chk("R10 level bits not writable", v & 16'h0003, 16'h0001);

    // R11: each mask bit selects its source
    wr(3'd2, 16'h0001); chk("R11 tx request source", {15'h0, irq}, 16'h1);
    wr(3'd2, 16'h0002); chk("R11 rx request idle", {15'h0, irq}, 16'h0);
    wr(3'd2, 16'h0004); chk("R11 underrun source", {15'h0, irq}, 16'h1);

    repeat (3) cyc();
    if (tx_exp.size() != 0 || rx_exp.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL R2 pending results actual=%0d expected=0", tx_exp.size() + rx_exp.size());
    end
    summary();
    $finish;
  end
endmodule